// File: doc/BRIEF.md
# Burst Packet Transfer Engine

This block moves fixed-length packets between an on-chip byte stream and an already configured 2.4 GHz transceiver over a three-wire serial link: a chip-enable strobe, a bit clock and one data wire whose direction turns around between transmit and receive. Configuration of the radio, CRC handling and the radio itself sit outside the block.

While idle the engine keeps chip-enable high so the radio listens. A transmit request carries the destination address. The engine re-raises chip-enable and waits a setup interval. It then clocks out the address bytes and after them the payload bytes taken from the input stream. Dropping chip-enable tells the radio to send the burst, and the engine then holds off for a settling interval before it listens again. When the radio raises its data-ready line, the engine drops chip-enable and clocks in one payload. It hands each byte to the output stream, with a last flag on the final byte, and then raises chip-enable again.

Top module: `burst_xfer_engine`

## Requirements
- R1: While reset is held and after it is released, rf_ce, rf_clk and rf_doe are low, and m_tvalid and s_tready are low. rf_ce first rises no sooner than SETTLE_CYC cycles after reset release.
- R2: tx_ack is a single-cycle pulse. It is given only while listening (rf_ce high, no frame running) with tx_req high and rf_dr low. The tx_addr value present in that cycle is the address that is sent.
- R3: A transmit frame begins with a rising edge of rf_ce. At least SETUP_CYC clock cycles pass between that edge and the first rising edge of rf_clk.
- R4: A frame carries ADDR_BYTES address bytes, the most significant byte of tx_addr first, and then PAYLOAD_BYTES bytes from the input stream. Each byte goes most significant bit first on rf_dout, valid at the rising edge of rf_clk. rf_clk stays high for exactly HALF_CYC cycles per bit.
- R5: If no payload byte is offered when one is due, rf_clk is held low until s_tvalid is seen with s_tready. Each byte is taken in exactly one handshake cycle.
- R6: A frame ends with rf_ce falling while rf_clk is low. rf_ce then stays low, and no tx_ack is given, for at least SETTLE_CYC cycles before listening resumes.
- R7: rf_doe is high only inside a transmit frame, while rf_ce is high. It is low throughout a receive, so the data wire is released.
- R8: When rf_dr is high while listening, rf_ce falls and PAYLOAD_BYTES bytes are clocked in, most significant bit first. Each bit is sampled from rf_din in the last cycle of the rf_clk high phase, and each byte appears on m_tdata in arrival order.
- R9: m_tlast is high with the final received byte only. While m_tvalid is high and m_tready is low, m_tdata and m_tlast hold and rf_clk stays low.
- R10: After the final received byte is accepted, rf_ce rises with rf_clk low and the engine listens again.
- R11: If rf_dr and tx_req are both high in the same listening cycle, the receive runs first. The transmit is not acknowledged until every received byte has been delivered, and it then proceeds normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Transmit request, held until acknowledged |
| tx_addr | input | 8*ADDR_BYTES | Destination address for the requested frame |
| tx_ack | output | 1 | Request accepted this cycle |
| s_tdata | input | 8 | Payload byte to send |
| s_tvalid | input | 1 | Payload byte offered |
| s_tready | output | 1 | Payload byte taken this cycle if offered |
| m_tdata | output | 8 | Received byte |
| m_tvalid | output | 1 | Received byte available |
| m_tready | input | 1 | Consumer accepts received byte |
| m_tlast | output | 1 | Final byte of the received packet |
| rf_ce | output | 1 | Radio chip-enable |
| rf_clk | output | 1 | Serial bit clock to radio |
| rf_dout | output | 1 | Serial data toward radio |
| rf_doe | output | 1 | Drive enable for the data wire pad |
| rf_din | input | 1 | Serial data from radio |
| rf_dr | input | 1 | Radio data-ready |

## Verification
A pending received packet and a new transmit request can reach the listening state in the same cycle. The arbitration between them is the one collision this engine has. The bench provokes it by raising rf_dr and tx_req on the same clock edge. It then judges that no acknowledge appears until the received bytes have all left the output stream, that those bytes are intact, and that the delayed transmit frame still carries the right address and payload after the settling interval.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_LISTEN,
    ST_TXARM,
    ST_TXSETUP,
    ST_TXLOAD,
    ST_TXSHIFT,
    ST_RXSHIFT,
    ST_RXHOLD
  } burst_state_e;

  // byte idx of an address, counted from the least significant byte
  function automatic logic [7:0] addr_byte(input logic [39:0] addr, input int unsigned idx);
    return addr[idx*8 +: 8];
  endfunction

  // bytes clocked out in one transmit frame
  function automatic int unsigned frame_bytes(input int unsigned abytes, input int unsigned pbytes);
    return abytes + pbytes;
  endfunction

endpackage

// File: rtl/burst_bit_clock.sv
module burst_bit_clock #(
  parameter int HALF_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic sample_evt,
  output logic byte_end
);
  localparam int HW = $clog2(HALF_CYC + 1);

  logic [HW-1:0] hcnt;
  logic          phase;
  logic [2:0]    bitn;
  logic          half_end;

  assign half_end   = run && (hcnt == HW'(HALF_CYC - 1));
  assign sample_evt = half_end && phase;
  assign byte_end   = sample_evt && (bitn == 3'd7);
  assign sclk       = phase;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      hcnt  <= '0;
      phase <= 1'b0;
      bitn  <= 3'd0;
    end else if (half_end) begin
      hcnt  <= '0;
      phase <= ~phase;
      if (phase) bitn <= bitn + 3'd1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // a stopped bit clock parks low
  p_idle_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);

  // the clock falls right after the eighth sample
  p_byte_end_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |=> !sclk);

endmodule

// File: rtl/burst_wait_count.sv
module burst_wait_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = run && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!expired)  cnt <= cnt + 1'b1;
  end

  p_expire_ends_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !expired);

endmodule

// File: rtl/burst_xfer_engine.sv
module burst_xfer_engine
  import burst_pkg::*;
#(
  parameter int ADDR_BYTES    = 2,
  parameter int PAYLOAD_BYTES = 2,
  parameter int HALF_CYC      = 50,
  parameter int SETUP_CYC     = 500,
  parameter int SETTLE_CYC    = 50000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tx_req,
  input  logic [8*ADDR_BYTES-1:0] tx_addr,
  output logic                    tx_ack,
  input  logic [7:0]              s_tdata,
  input  logic                    s_tvalid,
  output logic                    s_tready,
  output logic [7:0]              m_tdata,
  output logic                    m_tvalid,
  input  logic                    m_tready,
  output logic                    m_tlast,
  output logic                    rf_ce,
  output logic                    rf_clk,
  output logic                    rf_dout,
  output logic                    rf_doe,
  input  logic                    rf_din,
  input  logic                    rf_dr
);
  localparam int TOT  = int'(frame_bytes(ADDR_BYTES, PAYLOAD_BYTES));
  localparam int BW   = $clog2(TOT + 1);
  localparam int WMAX = (SETUP_CYC > SETTLE_CYC) ? SETUP_CYC : SETTLE_CYC;
  localparam int WW   = $clog2(WMAX + 1);

  burst_state_e            state, state_nx;
  logic [8*ADDR_BYTES-1:0] addr_q;
  logic [39:0]             addr_ext;
  logic [7:0]              sr;
  logic [BW-1:0]           bytecnt;

  // named internal events
  logic in_listen, rx_go, pay_phase, s_take, m_take, rx_final, tx_final;
  logic bit_run, sample_evt, byte_end, wait_run, wait_done;
  logic [WW-1:0] wait_limit;

  assign addr_ext  = 40'(addr_q);
  assign in_listen = (state == ST_LISTEN);
  assign rx_go     = in_listen && rf_dr;
  assign tx_ack    = in_listen && tx_req && !rf_dr;
  assign pay_phase = (bytecnt >= BW'(ADDR_BYTES));
  assign s_tready  = (state == ST_TXLOAD) && pay_phase;
  assign s_take    = s_tready && s_tvalid;
  assign m_take    = m_tvalid && m_tready;
  assign rx_final  = (bytecnt == BW'(PAYLOAD_BYTES - 1));
  assign tx_final  = (bytecnt == BW'(TOT - 1));

  assign bit_run    = (state == ST_TXSHIFT) || (state == ST_RXSHIFT);
  assign wait_run   = (state == ST_SETTLE) || (state == ST_TXSETUP);
  assign wait_limit = (state == ST_TXSETUP) ? WW'(SETUP_CYC) : WW'(SETTLE_CYC);

  burst_bit_clock #(.HALF_CYC(HALF_CYC)) u_bit (
    .clk(clk), .rst_n(rst_n), .run(bit_run),
    .sclk(rf_clk), .sample_evt(sample_evt), .byte_end(byte_end)
  );

  burst_wait_count #(.W(WW)) u_wait (
    .clk(clk), .rst_n(rst_n), .run(wait_run),
    .limit(wait_limit), .expired(wait_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_SETTLE:  if (wait_done) state_nx = ST_LISTEN;
      ST_LISTEN:  if (rx_go) state_nx = ST_RXSHIFT;
                  else if (tx_ack) state_nx = ST_TXARM;
      ST_TXARM:   state_nx = ST_TXSETUP;
      ST_TXSETUP: if (wait_done) state_nx = ST_TXLOAD;
      ST_TXLOAD:  if (!pay_phase || s_take) state_nx = ST_TXSHIFT;
      ST_TXSHIFT: if (byte_end) state_nx = tx_final ? ST_SETTLE : ST_TXLOAD;
      ST_RXSHIFT: if (byte_end) state_nx = ST_RXHOLD;
      ST_RXHOLD:  if (m_take) state_nx = rx_final ? ST_LISTEN : ST_RXSHIFT;
      default:    state_nx = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_SETTLE;
      addr_q  <= '0;
      sr      <= 8'h00;
      bytecnt <= '0;
    end else begin
      state <= state_nx;
      if (tx_ack) addr_q <= tx_addr;
      unique case (state)
        ST_LISTEN:  bytecnt <= '0;
        ST_TXLOAD:  if (!pay_phase) sr <= addr_byte(addr_ext, ADDR_BYTES - 1 - int'(bytecnt));
                    else if (s_take) sr <= s_tdata;
        ST_TXSHIFT: begin
          if (sample_evt) sr <= {sr[6:0], 1'b0};
          if (byte_end) bytecnt <= bytecnt + 1'b1;
        end
        ST_RXSHIFT: if (sample_evt) sr <= {sr[6:0], rf_din};
        ST_RXHOLD:  if (m_take) bytecnt <= bytecnt + 1'b1;
        default: ;
      endcase
    end
  end

  assign rf_ce    = (state == ST_LISTEN) || (state == ST_TXSETUP) ||
                    (state == ST_TXLOAD) || (state == ST_TXSHIFT);
  assign rf_doe   = (state == ST_TXSETUP) || (state == ST_TXLOAD) || (state == ST_TXSHIFT);
  assign rf_dout  = rf_doe && sr[7];
  assign m_tvalid = (state == ST_RXHOLD);
  assign m_tdata  = sr;
  assign m_tlast  = m_tvalid && rx_final;

  // the data wire is driven only inside a transmit frame
  p_oe_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_doe |-> rf_ce);

  // chip-enable never moves while the bit clock is high
  p_ce_edge_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rf_ce) || $fell(rf_ce)) |-> !rf_clk);

  // a stalled output byte holds and the link clock waits
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  p_clk_low_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> !rf_clk);

  // acceptance only while listening, never with a receive byte pending
  p_ack_listen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |-> (rf_ce && !rf_doe && !m_tvalid && !rf_clk));

  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |=> !tx_ack);

  // payload is requested only between bytes, with the clock parked
  p_take_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_tready |-> (!rf_clk && rf_doe));

endmodule

// File: tb/sim_burst_xfer_engine.sv
module sim_burst_xfer_engine;
  localparam int AB     = 3;
  localparam int PB     = 3;
  localparam int HALF   = 2;
  localparam int SETUP  = 12;
  localparam int SETTLE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_req = 1'b0;
  logic [8*AB-1:0] tx_addr = '0;
  logic tx_ack;
  logic [7:0] s_tdata = 8'h00;
  logic s_tvalid = 1'b0;
  logic s_tready;
  logic [7:0] m_tdata;
  logic m_tvalid;
  logic m_tready = 1'b0;
  logic m_tlast;
  logic rf_ce, rf_clk, rf_dout, rf_doe;
  logic rf_din = 1'b0;
  logic rf_dr = 1'b0;

  always #10 clk = ~clk;

  burst_xfer_engine #(
    .ADDR_BYTES(AB), .PAYLOAD_BYTES(PB), .HALF_CYC(HALF),
    .SETUP_CYC(SETUP), .SETTLE_CYC(SETTLE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_addr(tx_addr), .tx_ack(tx_ack),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
    .rf_ce(rf_ce), .rf_clk(rf_clk), .rf_dout(rf_dout), .rf_doe(rf_doe),
    .rf_din(rf_din), .rf_dr(rf_dr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic       rxl_q[$];
  logic       bit_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor and radio model, away from the active edge
  int cyc = 0;
  int ce_rise_cyc = 0, clk_rise_cyc = 0, tx_end_cyc = 0;
  logic p_clk = 0, p_ce = 0, p_doe = 0;
  bit first_bit = 0, in_settle = 1, first_settle = 1;
  logic [7:0] tx_shift = 0;
  int nb = 0, frame_bits = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (rf_ce && !p_ce) begin
        ce_rise_cyc = cyc;
        first_bit = 1;
        frame_bits = 0;
        if (in_settle) begin
          if (first_settle)
            chk(cyc >= SETTLE, "R1 first listen after reset", cyc, SETTLE);
          else
            chk(cyc - tx_end_cyc >= SETTLE, "R6 settle interval", cyc - tx_end_cyc, SETTLE);
          in_settle = 0;
          first_settle = 0;
        end else begin
          chk(!rf_clk && rx_q.size() == 0, "R10 listen again after receive",
              {rf_clk, 8'(rx_q.size())}, 0);
        end
      end
      if (rf_clk && !p_clk) begin
        clk_rise_cyc = cyc;
        if (rf_doe) begin
          if (first_bit) begin
            chk(cyc - ce_rise_cyc >= SETUP, "R3 setup before first clock", cyc - ce_rise_cyc, SETUP);
            first_bit = 0;
          end
          tx_shift = {tx_shift[6:0], rf_dout};
          nb++;
          frame_bits++;
          if (nb == 8) begin
            nb = 0;
            if (tx_q.size() == 0) chk(0, "R4 unexpected transmit byte", tx_shift, 0);
            else begin
              logic [7:0] e;
              e = tx_q.pop_front();
              chk(tx_shift == e, "R4 transmit byte order", tx_shift, e);
            end
          end
        end else begin
          chk(!rf_ce, "R7 receive clock with data wire released", rf_ce, 0);
          rf_dr = 1'b0;
        end
      end
      if (!rf_clk && p_clk) begin
        chk(cyc - clk_rise_cyc == HALF, "R4 clock high time", cyc - clk_rise_cyc, HALF);
        if (!rf_ce && bit_q.size() > 0) rf_din = bit_q.pop_front();
      end
      if (!rf_ce && p_ce && p_doe) begin
        chk(!rf_clk, "R6 ce falls with clock low", rf_clk, 0);
        chk(frame_bits == 8*(AB+PB), "R4 frame length in bits", frame_bits, 8*(AB+PB));
        tx_end_cyc = cyc;
        in_settle = 1;
      end
      if (tx_ack) begin
        chk(!in_settle && rf_ce, "R6 no accept during settle", in_settle, 0);
        chk(rx_q.size() == 0 && !rf_dr, "R11 transmit waits for receive", rx_q.size(), 0);
      end
      if (m_tvalid && m_tready) begin
        if (rx_q.size() == 0) chk(0, "R8 unexpected received byte", m_tdata, 0);
        else begin
          logic [7:0] e;
          logic el;
          e = rx_q.pop_front();
          el = rxl_q.pop_front();
          chk(m_tdata == e, "R8 received byte", m_tdata, e);
          chk(m_tlast == el, "R9 last flag", m_tlast, el);
        end
      end
      p_clk = rf_clk;
      p_ce = rf_ce;
      p_doe = rf_doe;
    end
  end

  // consumer with a repeating back-pressure pattern
  initial begin
    int k = 0;
    forever begin
      @(posedge clk);
      #1;
      m_tready = (k % 3) != 1;
      k++;
    end
  end

  task automatic do_tx(input logic [8*AB-1:0] a, input logic [7:0] pl [PB], input int gap);
    for (int i = AB - 1; i >= 0; i--) tx_q.push_back(a[8*i +: 8]);
    for (int j = 0; j < PB; j++) tx_q.push_back(pl[j]);
    @(posedge clk);
    #1;
    tx_req = 1'b1;
    tx_addr = a;
    do @(negedge clk); while (!tx_ack);
    @(posedge clk);
    #1;
    tx_req = 1'b0;
    tx_addr = '0;
    for (int j = 0; j < PB; j++) begin
      repeat (gap) @(posedge clk);
      #1;
      s_tvalid = 1'b1;
      s_tdata = pl[j];
      do @(negedge clk); while (!s_tready);
      @(posedge clk);
      #1;
      s_tvalid = 1'b0;
      s_tdata = 8'h00;
    end
    do @(negedge clk); while (tx_q.size() != 0 || rf_ce);
  endtask

  task automatic do_rx(input logic [7:0] pl [PB]);
    for (int j = 0; j < PB; j++) begin
      rx_q.push_back(pl[j]);
      rxl_q.push_back(j == PB - 1);
      for (int b = 7; b >= 0; b--) bit_q.push_back(pl[j][b]);
    end
    @(posedge clk);
    #1;
    rf_din = bit_q.pop_front();
    rf_dr = 1'b1;
    do @(negedge clk); while (rx_q.size() != 0);
  endtask

  task automatic wait_listen();
    do @(negedge clk); while (!(rf_ce && !rf_doe && !in_settle));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rf_ce && !rf_clk && !rf_doe, "R1 pins low in reset", {rf_ce, rf_clk, rf_doe}, 0);
    chk(!m_tvalid && !s_tready && !tx_ack, "R1 streams idle in reset", {m_tvalid, s_tready, tx_ack}, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rf_ce && !rf_doe, "R1 ce low after release", rf_ce, 0);
    wait_listen();

    do_tx(24'hA1B2C3, '{8'h11, 8'h22, 8'h33}, 0);
    wait_listen();
    do_tx(24'h00FF01, '{8'h80, 8'h7F, 8'h00}, 5);   // R5 payload gaps
    wait_listen();
    do_rx('{8'h5A, 8'hC3, 8'h01});
    wait_listen();
    do_rx('{8'hFF, 8'h00, 8'h96});
    wait_listen();
    fork   // R11 collision of data-ready and request
      do_rx('{8'h3C, 8'hE7, 8'h42});
      do_tx(24'h123456, '{8'hDE, 8'hAD, 8'hBE}, 1);
    join
    wait_listen();
    chk(tx_q.size() == 0 && rx_q.size() == 0, "R2 all scoreboard items consumed",
        tx_q.size() + rx_q.size(), 0);
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

endmodule